// File: doc/BRIEF.md
# Sync-Relative Edge Timestamp Capture

This block times the first edge on each of four digital inputs against the system sync pulse. A shared ramp counter advances once per microsecond tick. It restarts at zero on every sync strobe. It also restarts when it reaches a programmable period limit, so a lost sync never makes it overflow. Each input channel has its own edge selection. Within one sync period, the first qualifying edge on a channel stores the current ramp value in a private capture latch. Any later edge in that period has no effect.

On each sync strobe, every channel copies its latch into a readable result register. A channel that saw no qualifying edge reports the all-ones sentinel. Software sets the edge selection and the period limit through a small word-wide register port, and reads the results back through the same port. Writing the edge-selection register discards every latch and result.

The inputs are expected to be synchronised to the clock and filtered before they reach the block. Sync is taken as it arrives: nothing is interpolated between sync pulses.

Top module: `sync_edge_stamp`

## Requirements
- R1: The ramp counter goes up by one on each clock with `tick_us` high and keeps its value on a clock with `tick_us` low. A `sync_in` strobe forces it to zero, and this takes priority over the tick.
- R2: A tick that would bring the ramp to the period limit sets it to zero instead, so the ramp runs 0 to limit-1. A limit of 0 holds the ramp at 0.
- R3: The period limit register is at address 1, is 16 bits wide, counts in microseconds, resets to 1000 and reads back what was written.
- R4: The edge-select register is at address 0. Channel n uses bits [2n+1:2n] of it. The code 1 selects rising edges, 2 selects falling edges, 3 selects both and 0 selects none. An edge is a change of the input between two consecutive clocks.
- R5: The first qualifying edge of a sync period stores the ramp value from the clock in which the input changed. Every later edge in the same period is ignored.
- R6: A result changes only on a `sync_in` strobe. It then takes the captured value, or 0xFFFF when the ending period held no qualifying edge.
- R7: After reset, every result is 0xFFFF and the edge-select register is 0.
- R8: A write to the edge-select register clears every capture latch and sets every result to 0xFFFF in the same clock.
- R9: A channel with edge select 0 never captures and reports 0xFFFF after every sync.
- R10: An edge in the same clock as `sync_in` belongs to the new period and is captured with timestamp 0.
- R11: `rd_data` shows, one clock after `rd_addr` is applied, the register at that address: edge select at 0, period limit at 1, the result of channel n at 2+n. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-clock pulse every microsecond |
| sync_in | input | 1 | One-clock system sync strobe |
| din | input | 4 | Synchronised digital inputs, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Registered read data |

## Verification
A capture lands in the clock edge where the input change is first seen, so the ramp value it stores is the number of ticks applied since the sync edge. The result becomes visible in the sync clock itself, and a read returns it one clock after the address is applied. The bench changes inputs only after a falling edge and holds ticks low in clocks where an input changes, so the expected timestamp is just the tick count. It reads `rd_data` at the falling edge that follows the registering clock.

// File: rtl/ses_pkg.sv
package ses_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RISE = 2'd1,
    SEL_FALL = 2'd2,
    SEL_BOTH = 2'd3
  } edge_sel_e;

  localparam int SEL_W = 2;
endpackage

// File: rtl/ses_ramp.sv
module ses_ramp #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            sync,
  input  logic [TS_W-1:0] limit,
  output logic [TS_W-1:0] ramp
);
  logic [TS_W:0] nxt;

  assign nxt = {1'b0, ramp} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ramp <= '0;
    end else if (sync) begin
      ramp <= '0;
    end else if (tick) begin
      if (nxt >= {1'b0, limit}) ramp <= '0;
      else                      ramp <= nxt[TS_W-1:0];
    end
  end

  AST_SYNC_ZEROES: assert property (@(posedge clk) disable iff (rst)
    sync |=> (ramp == '0)); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!sync && !tick) |=> $stable(ramp)); // R1
  AST_WRAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    (tick && !sync && (limit != '0) && (ramp < limit)) |=> (ramp < $past(limit))); // R2
endmodule

// File: rtl/ses_chan.sv
module ses_chan
  import ses_pkg::*;
#(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            sync,
  input  logic            din,
  input  edge_sel_e       sel,
  input  logic [TS_W-1:0] ramp,
  output logic [TS_W-1:0] result
);
  logic            prev;
  logic            hit;
  logic            valid;
  logic [TS_W-1:0] latch;
  logic            rise;
  logic            fall;

  assign rise = din & ~prev;
  assign fall = ~din & prev;

  always_comb begin
    case (sel)
      SEL_RISE: hit = rise;
      SEL_FALL: hit = fall;
      SEL_BOTH: hit = rise | fall;
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= din;
      valid  <= 1'b0;
      latch  <= '0;
      result <= '1;
    end else begin
      prev <= din;
      if (clr) begin
        valid  <= 1'b0;
        latch  <= '0;
        result <= '1;
      end else if (sync) begin
        result <= valid ? latch : '1;
        valid  <= hit;
        latch  <= '0;
      end else if (hit && !valid) begin
        latch <= ramp;
        valid <= 1'b1;
      end
    end
  end

  AST_FIRST_ONLY: assert property (@(posedge clk) disable iff (rst)
    (valid && !sync && !clr) |=> $stable(latch)); // R5
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    (!sync && !clr) |=> $stable(result)); // R6
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
    clr |=> ((result == '1) && !valid)); // R8
  AST_NONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_NONE) |=> !valid); // R9
endmodule

// File: rtl/ses_regs.sv
module ses_regs #(
  parameter int NUM_CH     = 4,
  parameter int TS_W       = 16,
  parameter int ADDR_W     = 4,
  parameter int PERIOD_RST = 1000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [TS_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [NUM_CH*TS_W-1:0] results,
  output logic [2*NUM_CH-1:0]    cfg,
  output logic [TS_W-1:0]        period,
  output logic                   clr,
  output logic [TS_W-1:0]        rd_data
);
  localparam int CFG_W = 2 * NUM_CH;
  localparam logic [ADDR_W-1:0] ADDR_CFG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_PER = ADDR_W'(1);
  localparam int TS_BASE = 2;

  logic [TS_W-1:0] rd_nxt;

  assign clr = wr_en && (wr_addr == ADDR_CFG);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= '0;
      period <= TS_W'(PERIOD_RST);
    end else if (wr_en) begin
      if (wr_addr == ADDR_CFG) cfg    <= wr_data[CFG_W-1:0];
      if (wr_addr == ADDR_PER) period <= wr_data;
    end
  end

  always_comb begin
    rd_nxt = '0;
    if (rd_addr == ADDR_CFG) rd_nxt = TS_W'(cfg);
    if (rd_addr == ADDR_PER) rd_nxt = period;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_addr == ADDR_W'(TS_BASE + i)) rd_nxt = results[i*TS_W +: TS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end

  AST_PERIOD_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (wr_addr == ADDR_PER)) |=> $stable(period)); // R3
endmodule

// File: rtl/sync_edge_stamp.sv
module sync_edge_stamp
  import ses_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int TS_W       = 16,
  parameter int ADDR_W     = 4,
  parameter int PERIOD_RST = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_us,
  input  logic              sync_in,
  input  logic [NUM_CH-1:0] din,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TS_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [TS_W-1:0]   rd_data
);
  logic [TS_W-1:0]          ramp;
  logic [TS_W-1:0]          period;
  logic [SEL_W*NUM_CH-1:0]  cfg;
  logic                     clr;
  logic [NUM_CH*TS_W-1:0]   results;

  ses_ramp #(.TS_W(TS_W)) u_ramp (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick_us),
    .sync  (sync_in),
    .limit (period),
    .ramp  (ramp)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    ses_chan #(.TS_W(TS_W)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr),
      .sync   (sync_in),
      .din    (din[g]),
      .sel    (edge_sel_e'(cfg[g*SEL_W +: SEL_W])),
      .ramp   (ramp),
      .result (results[g*TS_W +: TS_W])
    );
  end

  ses_regs #(
    .NUM_CH     (NUM_CH),
    .TS_W       (TS_W),
    .ADDR_W     (ADDR_W),
    .PERIOD_RST (PERIOD_RST)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .results (results),
    .cfg     (cfg),
    .period  (period),
    .clr     (clr),
    .rd_data (rd_data)
  );
endmodule

// File: tb/tb_sync_edge_stamp.sv
module tb_sync_edge_stamp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_us = 1'b0;
  logic        sync_in = 1'b0;
  logic [3:0]  din = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int total = 0;
  int bad = 0;

  sync_edge_stamp dut (
    .clk(clk), .rst(rst), .tick_us(tick_us), .sync_in(sync_in), .din(din),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic s);
    tick_us = t;
    sync_in = s;
    @(posedge clk);
    @(negedge clk);
    tick_us = 1'b0;
    sync_in = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  function automatic logic qual(input int sel, input logic rising);
    return (sel == 3) || (sel == 1 && rising) || (sel == 2 && !rising);
  endfunction

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // Reset state: R7, R3, R11
    rd(4'd0, v); check("R7 cfg", v, 16'h0000);
    rd(4'd1, v); check("R3 period", v, 16'd1000);
    for (int c = 0; c < 4; c++) begin
      rd(4'(2 + c), v); check("R7 result", v, 16'hFFFF);
    end
    rd(4'd9, v); check("R11 unmapped", v, 16'h0000);

    // Sweep channel x select x edge polarity: R4 R5 R9 R1
    for (int ch = 0; ch < 4; ch++) begin
      for (int sel = 0; sel < 4; sel++) begin
        for (int st = 0; st < 2; st++) begin
          int n;
          int m;
          logic [15:0] exp;
          n = 3 + ch * 5 + sel;
          m = 4;
          wr(4'd0, 16'(sel * 8'h55));
          din[ch] = st[0];
          step(1'b0, 1'b0);
          step(1'b0, 1'b1);
          ticks(n);
          din[ch] = ~st[0];
          step(1'b0, 1'b0);
          ticks(m);
          din[ch] = st[0];
          step(1'b0, 1'b0);
          step(1'b0, 1'b1);
          if (qual(sel, st == 0))      exp = 16'(n);
          else if (qual(sel, st != 0)) exp = 16'(n + m);
          else                         exp = 16'hFFFF;
          rd(4'(2 + ch), v);
          check("R5 R4 R9 sweep", v, exp);
          rd(4'(2 + ((ch + 1) % 4)), v);
          check("R6 idle channel", v, 16'hFFFF);
          din[ch] = 1'b0;
          step(1'b0, 1'b0);
        end
      end
    end

    // Wrap at period limit: R2, result stable between syncs R6
    wr(4'd1, 16'd8);
    rd(4'd1, v); check("R3 period write", v, 16'd8);
    wr(4'd0, 16'h0001);
    step(1'b0, 1'b1);
    ticks(20);
    din[0] = 1'b1;
    step(1'b0, 1'b0);
    rd(4'd2, v); check("R6 before sync", v, 16'hFFFF);
    step(1'b0, 1'b1);
    rd(4'd2, v); check("R2 wrap", v, 16'd4);
    wr(4'd1, 16'd0);
    step(1'b0, 1'b1);
    ticks(5);
    din[0] = 1'b0;
    step(1'b0, 1'b0);
    din[0] = 1'b1;
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    rd(4'd2, v); check("R2 zero limit", v, 16'd0);
    din[0] = 1'b0;
    wr(4'd1, 16'd1000);

    // Edge together with sync: R10
    wr(4'd0, 16'h00FF);
    step(1'b0, 1'b1);
    ticks(2);
    din[1] = 1'b1;
    step(1'b0, 1'b1);
    ticks(5);
    din[1] = 1'b0;
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    rd(4'd3, v); check("R10 same cycle", v, 16'd0);

    // Config write clears: R8
    wr(4'd0, 16'h0010);
    step(1'b0, 1'b1);
    ticks(3);
    din[2] = 1'b1;
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    rd(4'd4, v); check("R6 result", v, 16'd3);
    din[2] = 1'b0;
    ticks(2);
    din[2] = 1'b1;
    step(1'b0, 1'b0);
    wr(4'd0, 16'h0010);
    rd(4'd4, v); check("R8 result cleared", v, 16'hFFFF);
    step(1'b0, 1'b1);
    rd(4'd4, v); check("R8 latch cleared", v, 16'hFFFF);
    rd(4'd0, v); check("R11 cfg read", v, 16'h0010);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule